// File: doc/BRIEF.md
# Four-State Select, Concatenate and Reduce Unit

This block works on signals held in value/mask form, where every bit carries a value bit and a mask bit. A clear mask bit means the bit is known and the value bit gives 0 or 1. A set mask bit means the bit is unknown. Within the unknown bits, a clear value bit means high-impedance (Z) and a set value bit means unknown (X). The unit performs five operations. It can pick one of two operands under control of a four-state condition. It can join two operands into one wider word. It can reduce one operand to a single bit with AND, OR or XOR. Any of these results can also be written into a 2-state destination.

Each request presents two operands, a condition, an opcode and a 2-state-target flag. The unit registers the result and raises a valid strobe on the next clock. Select and concatenate only move data. They never turn a Z bit into X. A simulation engine or checker can therefore use this unit to evaluate those operators without losing the difference between high-impedance and unknown.

Top module: `fsu_top`

## Requirements
- R1: Every cycle with `req_i` high is followed one clock later by a one-cycle `vld_o` pulse that carries that request's result. No pulse appears without a request. After reset `vld_o` is 0 and both result words are 0.
- R2: Each bit is encoded as (value, mask): (0,0) is 0, (1,0) is 1, (0,1) is Z and (1,1) is X. No operation changes a Z into an X, or an X into a Z, when it moves a bit.
- R3: Opcode 0 (select) with a fully known condition (`c_msk_i` all 0) returns the exact value/mask pair of operand A when `c_val_i` is nonzero, and of operand B when `c_val_i` is zero. Z bits in the chosen operand are kept. The upper W result bits are known 0.
- R4: Opcode 0 with any condition bit unknown (X or Z) returns X in all of the lower W bits. The upper W bits are known 0.
- R5: Opcode 1 (concatenate) returns {A, B} for both value and mask, with A in the upper W bits. Nothing is modified.
- R6: Opcode 2 reduces A with AND. The result is known 0 if any bit of A is a known 0. Otherwise it is X if any bit is unknown. Otherwise it is known 1.
- R7: Opcode 3 reduces A with OR. The result is known 1 if any bit of A is a known 1. Otherwise it is X if any bit is unknown. Otherwise it is known 0.
- R8: Opcode 4 reduces A with XOR. The result is X if any bit of A is unknown. Otherwise it is the XOR of A's value bits.
- R9: A reduction result sits in bit 0. All result bits above it are known 0.
- R10: When `two_state_i` is set, the whole result mask is 0 and the value bits are those the opcode would otherwise produce.
- R11: Opcodes 5 to 7 are reserved. They return X in every result bit, and R10 still applies to them.
- R12: In a cycle with `req_i` low, the result words keep the values they already hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe |
| op_i | input | 3 | Opcode: 0 select, 1 concatenate, 2 AND-reduce, 3 OR-reduce, 4 XOR-reduce |
| two_state_i | input | 1 | Result goes to a 2-state destination |
| a_val_i | input | W | Operand A value bits |
| a_msk_i | input | W | Operand A mask bits |
| b_val_i | input | W | Operand B value bits |
| b_msk_i | input | W | Operand B mask bits |
| c_val_i | input | W | Select condition value bits |
| c_msk_i | input | W | Select condition mask bits |
| res_val_o | output | 2W | Result value bits |
| res_msk_o | output | 2W | Result mask bits |
| vld_o | output | 1 | Result valid, one clock after the request |

## Verification
The bench builds the unit with W = 8, which gives a 16-bit result. Every mix of known, Z and X bits used here fits in short hand-written operands. With this width, a single Z bit among otherwise dominant bits shows at once whether a reduction lets a known 0 or a known 1 win. It also shows whether select and concatenate keep Z separate from X. The upper half of the output is exercised by concatenate and must read as known 0 for all other opcodes.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  typedef enum logic [2:0] {
    OP_SEL  = 3'd0,
    OP_CAT  = 3'd1,
    OP_RAND = 3'd2,
    OP_ROR  = 3'd3,
    OP_RXOR = 3'd4
  } fsu_op_e;
endpackage

// File: rtl/fsu_select.sv
module fsu_select #(
  parameter int W = 8
) (
  input  logic [W-1:0] c_val_i,
  input  logic [W-1:0] c_msk_i,
  input  logic [W-1:0] a_val_i,
  input  logic [W-1:0] a_msk_i,
  input  logic [W-1:0] b_val_i,
  input  logic [W-1:0] b_msk_i,
  output logic [W-1:0] y_val_o,
  output logic [W-1:0] y_msk_o,
  output logic         cond_unknown_o
);
  // Condition is uncertain when any of its bits is X or Z.
  function automatic logic cond_uncertain(input logic [W-1:0] m);
    return |m;
  endfunction

  logic take_a;
  assign cond_unknown_o = cond_uncertain(c_msk_i);
  assign take_a         = |c_val_i;

  always_comb begin
    if (cond_unknown_o) begin
      y_val_o = '1;
      y_msk_o = '1;
    end else if (take_a) begin
      y_val_o = a_val_i;
      y_msk_o = a_msk_i;
    end else begin
      y_val_o = b_val_i;
      y_msk_o = b_msk_i;
    end
  end
endmodule

// File: rtl/fsu_reduce.sv
module fsu_reduce import fsu_pkg::*; #(
  parameter int W = 8
) (
  input  fsu_op_e      op_i,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] msk_i,
  output logic         r_val_o,
  output logic         r_msk_o,
  output logic         has_known0_o,
  output logic         has_known1_o,
  output logic         has_unknown_o
);
  // Returns {value, mask} of the one-bit reduction.
  function automatic logic [1:0] reduce_pair(input fsu_op_e k, input logic [W-1:0] v,
                                             input logic [W-1:0] m);
    logic k0, k1, ux;
    k0 = |(~v & ~m);
    k1 = |(v & ~m);
    ux = |m;
    case (k)
      OP_RAND: return k0 ? 2'b00 : (ux ? 2'b11 : 2'b10);
      OP_ROR:  return k1 ? 2'b10 : (ux ? 2'b11 : 2'b00);
      OP_RXOR: return ux ? 2'b11 : {^v, 1'b0};
      default: return 2'b11;
    endcase
  endfunction

  logic [1:0] pair;
  assign has_known0_o  = |(~val_i & ~msk_i);
  assign has_known1_o  = |(val_i & ~msk_i);
  assign has_unknown_o = |msk_i;
  assign pair          = reduce_pair(op_i, val_i, msk_i);
  assign r_val_o       = pair[1];
  assign r_msk_o       = pair[0];
endmodule

// File: rtl/fsu_top.sv
module fsu_top import fsu_pkg::*; #(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic [2:0]      op_i,
  input  logic            two_state_i,
  input  logic [W-1:0]    a_val_i,
  input  logic [W-1:0]    a_msk_i,
  input  logic [W-1:0]    b_val_i,
  input  logic [W-1:0]    b_msk_i,
  input  logic [W-1:0]    c_val_i,
  input  logic [W-1:0]    c_msk_i,
  output logic [2*W-1:0]  res_val_o,
  output logic [2*W-1:0]  res_msk_o,
  output logic            vld_o
);
  localparam int OW = 2 * W;

  fsu_op_e     op;
  logic [W-1:0] sel_val, sel_msk;
  logic         sel_unk;
  logic         red_val, red_msk, red_k0, red_k1, red_ux;
  logic         is_reduce;
  logic [OW-1:0] nxt_val, nxt_msk;
  logic [OW-1:0] val_q, msk_q;
  logic          vld_q;

  assign op        = fsu_op_e'(op_i);
  assign is_reduce = (op == OP_RAND) || (op == OP_ROR) || (op == OP_RXOR);

  fsu_select #(.W(W)) u_sel (
    .c_val_i(c_val_i), .c_msk_i(c_msk_i),
    .a_val_i(a_val_i), .a_msk_i(a_msk_i),
    .b_val_i(b_val_i), .b_msk_i(b_msk_i),
    .y_val_o(sel_val), .y_msk_o(sel_msk),
    .cond_unknown_o(sel_unk)
  );

  fsu_reduce #(.W(W)) u_red (
    .op_i(op), .val_i(a_val_i), .msk_i(a_msk_i),
    .r_val_o(red_val), .r_msk_o(red_msk),
    .has_known0_o(red_k0), .has_known1_o(red_k1), .has_unknown_o(red_ux)
  );

  always_comb begin
    nxt_val = '0;
    nxt_msk = '0;
    case (op)
      OP_SEL: begin
        nxt_val[W-1:0] = sel_val;
        nxt_msk[W-1:0] = sel_msk;
      end
      OP_CAT: begin
        nxt_val = {a_val_i, b_val_i};
        nxt_msk = {a_msk_i, b_msk_i};
      end
      OP_RAND, OP_ROR, OP_RXOR: begin
        nxt_val[0] = red_val;
        nxt_msk[0] = red_msk;
      end
      default: begin
        nxt_val = '1;
        nxt_msk = '1;
      end
    endcase
    if (two_state_i) nxt_msk = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      val_q <= '0;
      msk_q <= '0;
    end else begin
      vld_q <= req_i;
      if (req_i) begin
        val_q <= nxt_val;
        msk_q <= nxt_msk;
      end
    end
  end

  assign res_val_o = val_q;
  assign res_msk_o = msk_q;
  assign vld_o     = vld_q;

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> vld_o); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !vld_o); // R1
  AST_SEL_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && op == OP_SEL && c_msk_i == '0 && !two_state_i) |=>
      (res_val_o[W-1:0] == ($past(c_val_i) != '0 ? $past(a_val_i) : $past(b_val_i)) &&
       res_msk_o[W-1:0] == ($past(c_val_i) != '0 ? $past(a_msk_i) : $past(b_msk_i)))); // R3
  AST_SEL_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && op == OP_SEL && sel_unk && !two_state_i) |=>
      (res_val_o[W-1:0] == '1 && res_msk_o[W-1:0] == '1)); // R4
  AST_CAT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && op == OP_CAT && !two_state_i) |=>
      (res_val_o == {$past(a_val_i), $past(b_val_i)} &&
       res_msk_o == {$past(a_msk_i), $past(b_msk_i)})); // R5
  AST_AND_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && op == OP_RAND && red_k0) |=> (res_val_o[0] == 1'b0 && res_msk_o[0] == 1'b0)); // R6
  AST_OR_ONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && op == OP_ROR && red_k1) |=> (res_val_o[0] == 1'b1 && res_msk_o[0] == 1'b0)); // R7
  AST_XOR_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && op == OP_RXOR && red_ux && !two_state_i) |=> res_msk_o[0]); // R8
  AST_RED_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && is_reduce) |=> (res_val_o[OW-1:1] == '0 && res_msk_o[OW-1:1] == '0)); // R9
  AST_TWO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && two_state_i) |=> res_msk_o == '0); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(res_val_o) && $stable(res_msk_o))); // R12
endmodule

// File: tb/fsu_top_tb_top.sv
module fsu_top_tb_top;
  localparam int BW = 8;
  localparam int RW = 2 * BW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0;
  logic [2:0] op_i = '0;
  logic two_state_i = 1'b0;
  logic [BW-1:0] a_val_i = '0, a_msk_i = '0, b_val_i = '0, b_msk_i = '0;
  logic [BW-1:0] c_val_i = '0, c_msk_i = '0;
  logic [RW-1:0] res_val_o, res_msk_o;
  logic vld_o;

  int total = 0;
  int bad = 0;
  logic [RW-1:0] q_val[$];
  logic [RW-1:0] q_msk[$];
  string q_tag[$];

  always #10 clk = ~clk;

  fsu_top #(.W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i), .two_state_i(two_state_i),
    .a_val_i(a_val_i), .a_msk_i(a_msk_i), .b_val_i(b_val_i), .b_msk_i(b_msk_i),
    .c_val_i(c_val_i), .c_msk_i(c_msk_i),
    .res_val_o(res_val_o), .res_msk_o(res_msk_o), .vld_o(vld_o)
  );

  task automatic check(input string tag, input logic [RW-1:0] av, am, ev, em);
    total++;
    if (av !== ev || am !== em) begin
      bad++;
      $display("FAIL %s: got val=%h msk=%h expected val=%h msk=%h", tag, av, am, ev, em);
    end
  endtask

  // Independent model written bit by bit from the requirements.
  task automatic model(input int op, input bit ts,
                       input logic [BW-1:0] av, am, bv, bm, cv, cm,
                       output logic [RW-1:0] ev, em);
    int zeros = 0, ones = 0, unk = 0, par = 0;
    ev = '0; em = '0;
    for (int i = 0; i < BW; i++) begin
      if (am[i]) unk++;
      else if (av[i]) begin ones++; par ^= 1; end
      else zeros++;
    end
    case (op)
      0: begin
        if (cm != 0) begin
          for (int i = 0; i < BW; i++) begin ev[i] = 1'b1; em[i] = 1'b1; end
        end else if (cv != 0) begin
          for (int i = 0; i < BW; i++) begin ev[i] = av[i]; em[i] = am[i]; end
        end else begin
          for (int i = 0; i < BW; i++) begin ev[i] = bv[i]; em[i] = bm[i]; end
        end
      end
      1: begin
        for (int i = 0; i < BW; i++) begin
          ev[i] = bv[i]; em[i] = bm[i];
          ev[i+BW] = av[i]; em[i+BW] = am[i];
        end
      end
      2: if (zeros > 0) ev[0] = 1'b0; else if (unk > 0) begin ev[0] = 1'b1; em[0] = 1'b1; end
         else ev[0] = 1'b1;
      3: if (ones > 0) ev[0] = 1'b1; else if (unk > 0) begin ev[0] = 1'b1; em[0] = 1'b1; end
         else ev[0] = 1'b0;
      4: if (unk > 0) begin ev[0] = 1'b1; em[0] = 1'b1; end else ev[0] = par[0];
      default: begin ev = {RW{1'b1}}; em = {RW{1'b1}}; end
    endcase
    if (ts) em = '0;
  endtask

  task automatic send(input string tag, input int op, input bit ts,
                      input logic [BW-1:0] av, am, bv, bm, cv, cm);
    logic [RW-1:0] ev, em;
    @(negedge clk);
    req_i = 1'b1; op_i = op[2:0]; two_state_i = ts;
    a_val_i = av; a_msk_i = am; b_val_i = bv; b_msk_i = bm; c_val_i = cv; c_msk_i = cm;
    model(op, ts, av, am, bv, bm, cv, cm, ev, em);
    q_val.push_back(ev); q_msk.push_back(em); q_tag.push_back(tag);
  endtask

  // Monitor: pops one expected item per valid result.
  always @(negedge clk) begin
    if (rst_n && vld_o) begin
      if (q_val.size() == 0) begin
        total++; bad++;
        $display("FAIL R1: valid with no request, got 1 expected 0");
      end else begin
        check(q_tag.pop_front(), res_val_o, res_msk_o, q_val.pop_front(), q_msk.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [RW-1:0] hv, hm;
    repeat (3) @(negedge clk);
    check("R1 reset", {res_val_o[RW-1:1], vld_o}, res_msk_o, '0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R3: known condition picks A with Z bits kept, or B with X bits kept
    send("R2 R3 sel A keeps Z", 0, 0, 8'h0F, 8'hF0, 8'h55, 8'h00, 8'h04, 8'h00);
    send("R3 sel B keeps X", 0, 0, 8'hAA, 8'h00, 8'hC3, 8'hC0, 8'h00, 8'h00);
    // R4: Z or X in the condition
    send("R4 cond Z", 0, 0, 8'h12, 8'h00, 8'h34, 8'h00, 8'h00, 8'h01);
    send("R4 cond X", 0, 0, 8'h12, 8'h0F, 8'h34, 8'h00, 8'h80, 8'h80);
    // R5: concatenation, A upper
    send("R2 R5 cat", 1, 0, 8'h3C, 8'h0F, 8'hA5, 8'hF0, 8'h00, 8'h00);
    // R6 R9: AND reduce
    send("R6 R9 and known0 wins", 2, 0, 8'hFE, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00);
    send("R6 R9 and Z gives X", 2, 0, 8'h7F, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00);
    send("R6 R9 and all ones", 2, 0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    // R7 R9: OR reduce
    send("R7 R9 or known1 wins", 3, 0, 8'h81, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00);
    send("R7 R9 or Z gives X", 3, 0, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00);
    send("R7 R9 or all zero", 3, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    // R8 R9: XOR reduce
    send("R8 R9 xor odd", 4, 0, 8'h07, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    send("R8 R9 xor even", 4, 0, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    send("R8 R9 xor with Z", 4, 0, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00);
    // R10: 2-state destination
    send("R10 sel unknown to 2-state", 0, 1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02);
    send("R10 cat to 2-state", 1, 1, 8'h0F, 8'hFF, 8'hF0, 8'h0F, 8'h00, 8'h00);
    send("R10 and X to 2-state", 2, 1, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
    // R11: reserved opcodes
    send("R11 op5", 5, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    send("R11 op7 2-state", 7, 1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    @(negedge clk);
    req_i = 1'b0;
    op_i = 3'd1; a_val_i = 8'h99; a_msk_i = 8'h66;
    hv = res_val_o; hm = res_msk_o;
    @(negedge clk);
    check("R12 hold while idle", res_val_o, res_msk_o, hv, hm);
    check("R1 no valid when idle", {15'd0, vld_o}, '0, '0, '0);
    repeat (3) @(negedge clk);
    if (q_val.size() != 0) begin
      total++; bad++;
      $display("FAIL R1: %0d results missing, expected 0", q_val.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule